// File: doc/BRIEF.md
# Synchronous Bus Clock Prescaler

This block derives four synchronous clock domains from one main clock: the processor domain, the high-speed bus domain and two peripheral bus domains. It does not produce divided clocks. Every block runs on the single fabric clock `clk`. The main clock is represented by a tick input, and each domain is represented by an enable strobe that is high on the main-clock ticks where that domain advances. The main clock is one of two tick sources, an oscillator tick or a PLL tick, and a control bit chooses between them.

Each domain can stay at the main rate or be slowed by a power of two. One shared clock-select register holds the settings for all four domains, and the block refuses any setting that would make a domain faster than its parent. Each domain also has a mask register. The mask gates the domain strobe into one enable per module, so modules with no users can be switched off.

Software programs the block through a write-only register port. It reads back the clock-select value, the selected source and a rejection flag.

Top module: `bus_clk_prescaler`

## Requirements
- R1: After reset the clock-select register reads 0 (all domains undivided), the oscillator tick is the main clock (`main_sel`=0), `sel_err` is 0, and every mask bit is set. With a tick on every cycle, every module enable is therefore high on every cycle.
- R2: Writing address 0 loads bit 0 of the write data into `main_sel`. When `main_sel` is 1, `pll_tick` is the main tick; when it is 0, `osc_tick` is the main tick. No domain strobe fires on a cycle without a main tick.
- R3: Address 1 holds the clock-select register. Byte d holds the setting for domain d, where 0 is CPU, 1 is the high-speed bus, 2 is peripheral bus A and 3 is peripheral bus B. In each byte, bit 7 is the divide enable and bits [2:0] are the select value S. If bit 7 is clear, the domain strobes on every main tick and S has no effect. If bit 7 is set, the domain strobes once every 2^(S+1) main ticks.
- R4: A clock-select write is rejected if it would give the CPU a larger divide exponent than the high-speed bus, or give the high-speed bus a larger exponent than either peripheral bus. A rejected write leaves the register unchanged and sets `sel_err`. An accepted write stores the data and clears `sel_err`.
- R5: The strobes are nested. The high-speed bus strobe fires only on cycles where the CPU strobe fires, and each peripheral strobe fires only on cycles where the high-speed bus strobe fires.
- R6: A new clock-select value reaches the strobes only at the wrap of the internal tick counter (every 2^(2^3) = 256 main ticks). The period running when the write happens is never shortened.
- R7: Addresses 2, 3, 4 and 5 hold the masks for CPU, high-speed bus, peripheral A and peripheral B. Bit i of a domain's mask enables module i of that domain, which appears at `mod_ce[d*32+i]`.
- R8: A domain's mask is captured only on that domain's strobe. A mask write therefore first affects the module enables at the second strobe of that domain after the write.
- R9: A module enable is high only on cycles where its domain strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Oscillator tick (main clock source 0) |
| pll_tick | input | 1 | PLL tick (main clock source 1) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| main_sel | output | 1 | Selected main clock source |
| clksel | output | 32 | Current clock-select register |
| sel_err | output | 1 | Last clock-select write was rejected |
| dom_ce | output | 4 | Domain strobes, CPU in bit 0 up to peripheral B in bit 3 |
| mod_ce | output | 4*MOD_W | Module enables, domain d at bits d*MOD_W and up |

## Verification
If the tick counter or a latched exponent is wrong, a domain shows a different number of strobes per counter period. It can also show a strobe that is not nested inside its parent's, and this appears at `dom_ce` within one period of the slowest active domain. A switch point in the wrong place shows up as a strobe gap shorter than either the old or the new period, right after a clock-select write. If a captured mask bit is wrong, the error appears at `mod_ce` on the next strobe of that domain, which can be up to 256 main ticks away when the domain is divided the most.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

   localparam int NUM_DOM   = 4;
   localparam int DOM_CPU   = 0;
   localparam int DOM_HSB   = 1;
   localparam int DOM_PBA   = 2;
   localparam int DOM_PBB   = 3;

   localparam int REG_W     = 32;
   localparam int FIELD_W   = 8;
   localparam int DIVEN_POS = 7;

   localparam int ADDR_MAIN      = 0;
   localparam int ADDR_CKSEL     = 1;
   localparam int ADDR_MASK_BASE = 2;

   // divide exponent of one domain: 0 when undivided, S+1 when divided
   function automatic int unsigned dom_exp(input logic [REG_W-1:0] v,
                                           input int d,
                                           input int sel_w);
      logic [FIELD_W-1:0] f;
      int unsigned        s;
      f = v[d*FIELD_W +: FIELD_W];
      s = 0;
      for (int b = 0; b < sel_w; b++) begin
         if (f[b]) s = s + (32'd1 << b);
      end
      return f[DIVEN_POS] ? s + 1 : 0;
   endfunction

   // parent domains must never be slower than their children
   function automatic logic order_ok(input logic [REG_W-1:0] v,
                                     input int sel_w);
      int unsigned e_cpu, e_hsb, e_pba, e_pbb;
      e_cpu = dom_exp(v, DOM_CPU, sel_w);
      e_hsb = dom_exp(v, DOM_HSB, sel_w);
      e_pba = dom_exp(v, DOM_PBA, sel_w);
      e_pbb = dom_exp(v, DOM_PBB, sel_w);
      return (e_cpu <= e_hsb) && (e_hsb <= e_pba) && (e_hsb <= e_pbb);
   endfunction

endpackage

// File: rtl/bcp_regs.sv
module bcp_regs #(
   parameter int SEL_W  = 3,
   parameter int MOD_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_en,
   input  logic [ADDR_W-1:0]                     wr_addr,
   input  logic [bcp_pkg::REG_W-1:0]             wr_data,
   output logic                                  main_sel,
   output logic [bcp_pkg::REG_W-1:0]             clksel,
   output logic                                  sel_err,
   output logic [bcp_pkg::NUM_DOM*MOD_W-1:0]     mask_flat
);
   import bcp_pkg::*;

   logic hit_main, hit_cksel, cksel_ok;

   assign hit_main  = wr_en && (wr_addr == ADDR_W'(ADDR_MAIN));
   assign hit_cksel = wr_en && (wr_addr == ADDR_W'(ADDR_CKSEL));
   assign cksel_ok  = order_ok(wr_data, SEL_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_sel <= 1'b0;
      end else if (hit_main) begin
         main_sel <= wr_data[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clksel  <= '0;
         sel_err <= 1'b0;
      end else if (hit_cksel) begin
         if (cksel_ok) begin
            clksel  <= wr_data;
            sel_err <= 1'b0;
         end else begin
            sel_err <= 1'b1;
         end
      end
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_mask
      logic hit_mask;
      assign hit_mask = wr_en && (wr_addr == ADDR_W'(ADDR_MASK_BASE + d));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_flat[d*MOD_W +: MOD_W] <= '1;
         end else if (hit_mask) begin
            mask_flat[d*MOD_W +: MOD_W] <= wr_data[MOD_W-1:0];
         end
      end
   end

endmodule

// File: rtl/bcp_divider.sv
module bcp_divider #(
   parameter int SEL_W = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            tick,
   input  logic [bcp_pkg::REG_W-1:0]       cfg,
   output logic [bcp_pkg::NUM_DOM-1:0]     dom_ce
);
   import bcp_pkg::*;

   localparam int CNT_W = 1 << SEL_W;
   localparam int EXP_W = SEL_W + 1;

   logic [CNT_W-1:0] cnt;
   logic             wrap;

   assign wrap = tick && (cnt == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + CNT_W'(1);
      end
   end

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      logic [EXP_W-1:0] act_exp;
      logic [CNT_W:0]   one_sh;
      logic [CNT_W-1:0] low_m;

      // new settings are latched on the last tick before the counter wraps
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_exp <= '0;
         end else if (wrap) begin
            act_exp <= EXP_W'(dom_exp(cfg, d, SEL_W));
         end
      end

      assign one_sh    = (CNT_W+1)'(1) << act_exp;
      assign low_m     = one_sh[CNT_W-1:0] - CNT_W'(1);
      assign dom_ce[d] = tick && ((cnt & low_m) == '0);
   end

endmodule

// File: rtl/bcp_gate.sv
module bcp_gate #(
   parameter int MOD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic [MOD_W-1:0] mask,
   output logic [MOD_W-1:0] mod_ce
);
   logic [MOD_W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (ce) begin
         mask_q <= mask;
      end
   end

   assign mod_ce = {MOD_W{ce}} & mask_q;

endmodule

// File: rtl/bus_clk_prescaler.sv
module bus_clk_prescaler #(
   parameter int SEL_W  = 3,
   parameter int MOD_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              osc_tick,
   input  logic                              pll_tick,
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [31:0]                       wr_data,
   output logic                              main_sel,
   output logic [31:0]                       clksel,
   output logic                              sel_err,
   output logic [3:0]                        dom_ce,
   output logic [4*MOD_W-1:0]                mod_ce
);
   import bcp_pkg::*;

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("SEL_W must lie in 1..4");
   end
   if (MOD_W < 1 || MOD_W > REG_W) begin : g_bad_mod
      $error("MOD_W must lie in 1..32");
   end
   if ((1 << ADDR_W) < ADDR_MASK_BASE + NUM_DOM) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic                       main_tick;
   logic [NUM_DOM*MOD_W-1:0]   mask_flat;

   assign main_tick = main_sel ? pll_tick : osc_tick;

   bcp_regs #(.SEL_W(SEL_W), .MOD_W(MOD_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .main_sel  (main_sel),
      .clksel    (clksel),
      .sel_err   (sel_err),
      .mask_flat (mask_flat)
   );

   bcp_divider #(.SEL_W(SEL_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (main_tick),
      .cfg    (clksel),
      .dom_ce (dom_ce)
   );

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_gate
      bcp_gate #(.MOD_W(MOD_W)) u_gate (
         .clk    (clk),
         .rst_n  (rst_n),
         .ce     (dom_ce[d]),
         .mask   (mask_flat[d*MOD_W +: MOD_W]),
         .mod_ce (mod_ce[d*MOD_W +: MOD_W])
      );
   end

endmodule

// File: rtl/bus_clk_prescaler_chk.sv
module bus_clk_prescaler_chk #(
   parameter int SEL_W  = 3,
   parameter int MOD_W  = 32,
   parameter int ADDR_W = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 osc_tick,
   input logic                 pll_tick,
   input logic                 wr_en,
   input logic [ADDR_W-1:0]    wr_addr,
   input logic [31:0]          wr_data,
   input logic                 main_sel,
   input logic [31:0]          clksel,
   input logic                 sel_err,
   input logic [3:0]           dom_ce,
   input logic [4*MOD_W-1:0]   mod_ce
);
   import bcp_pkg::*;

   logic cksel_wr, main_wr;
   assign cksel_wr = wr_en && (wr_addr == ADDR_W'(ADDR_CKSEL));
   assign main_wr  = wr_en && (wr_addr == ADDR_W'(ADDR_MAIN));

   p_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
      main_wr |=> (main_sel == $past(wr_data[0])));

   p_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(main_sel ? pll_tick : osc_tick) |-> (dom_ce == 4'b0000));

   p_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cksel_wr && !order_ok(wr_data, SEL_W)) |=> ($stable(clksel) && sel_err));

   p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cksel_wr && order_ok(wr_data, SEL_W)) |=> ((clksel == $past(wr_data)) && !sel_err));

   p_order_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
      order_ok(clksel, SEL_W));

   p_nest_hsb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dom_ce[DOM_HSB] |-> dom_ce[DOM_CPU]);

   p_nest_pba_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dom_ce[DOM_PBA] |-> dom_ce[DOM_HSB]);

   p_nest_pbb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      dom_ce[DOM_PBB] |-> dom_ce[DOM_HSB]);

   for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
      p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (|mod_ce[d*MOD_W +: MOD_W]) |-> dom_ce[d]);
   end

endmodule

bind bus_clk_prescaler bus_clk_prescaler_chk #(
   .SEL_W(SEL_W), .MOD_W(MOD_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .main_sel(main_sel), .clksel(clksel), .sel_err(sel_err),
   .dom_ce(dom_ce), .mod_ce(mod_ce)
);

// File: tb/bus_clk_prescaler_test.sv
module bus_clk_prescaler_test;

   localparam int MOD_W = 32;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               osc_tick = 1'b1;
   logic               pll_tick = 1'b0;
   logic               wr_en = 1'b0;
   logic [2:0]         wr_addr = '0;
   logic [31:0]        wr_data = '0;
   logic               main_sel;
   logic [31:0]        clksel;
   logic               sel_err;
   logic [3:0]         dom_ce;
   logic [4*MOD_W-1:0] mod_ce;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int dcnt [4];
   int mcnt [4];
   int viol;

   always #2 clk = ~clk;
   always @(negedge clk) pll_tick <= ~pll_tick;

   bus_clk_prescaler #(.SEL_W(3), .MOD_W(MOD_W), .ADDR_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .main_sel(main_sel), .clksel(clksel), .sel_err(sel_err),
      .dom_ce(dom_ce), .mod_ce(mod_ce)
   );

   typedef struct packed {
      logic [31:0] val;
      logic [31:0] q;
      logic        err;
      logic [9:0]  c0;
      logic [9:0]  c1;
      logic [9:0]  c2;
      logic [9:0]  c3;
   } vec_t;

   // clock-select write, expected register, expected flag, strobes per 512 ticks
   localparam vec_t VECS [8] = '{
      '{32'h00000000, 32'h00000000, 1'b0, 10'd512, 10'd512, 10'd512, 10'd512},
      '{32'h82818000, 32'h82818000, 1'b0, 10'd512, 10'd256, 10'd128, 10'd64},
      '{32'h80808080, 32'h80808080, 1'b0, 10'd256, 10'd256, 10'd256, 10'd256},
      '{32'h80808081, 32'h80808080, 1'b1, 10'd256, 10'd256, 10'd256, 10'd256},
      '{32'h87000000, 32'h87000000, 1'b0, 10'd512, 10'd512, 10'd512, 10'd2},
      '{32'h00008200, 32'h87000000, 1'b1, 10'd512, 10'd512, 10'd512, 10'd2},
      '{32'h07070707, 32'h07070707, 1'b0, 10'd512, 10'd512, 10'd512, 10'd512},
      '{32'h83838383, 32'h83838383, 1'b0, 10'd32,  10'd32,  10'd32,  10'd32}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic write_reg(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic run_window(input int n);
      for (int d = 0; d < 4; d++) begin
         dcnt[d] = 0;
         mcnt[d] = 0;
      end
      viol = 0;
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
         for (int d = 0; d < 4; d++) begin
            if (dom_ce[d]) dcnt[d]++;
            if (mod_ce[d*MOD_W]) mcnt[d]++;
         end
         if ((dom_ce[1] && !dom_ce[0]) || (dom_ce[2] && !dom_ce[1]) ||
             (dom_ce[3] && !dom_ce[1]))
            viol++;
      end
   endtask

   task automatic wait_strobe(input int d);
      do begin
         @(posedge clk);
         #1;
      end while (!dom_ce[d]);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      longint t0, t1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(posedge clk);
      #1;
      chk("R1 clksel reset", clksel, 32'h0);
      chk("R1 main_sel reset", {31'b0, main_sel}, 32'h0);
      chk("R1 sel_err reset", {31'b0, sel_err}, 32'h0);
      chk("R1 all module enables", {31'b0, &mod_ce}, 32'h1);

      // R3, R4, R5, R7: clock-select vectors
      for (int i = 0; i < 8; i++) begin
         write_reg(3'd1, VECS[i].val);
         chk("R4 clksel value", clksel, VECS[i].q);
         chk("R4 sel_err flag", {31'b0, sel_err}, {31'b0, VECS[i].err});
         wait_cycles(300);
         run_window(512);
         chk("R3 cpu strobes", dcnt[0], 32'(VECS[i].c0));
         chk("R3 hsb strobes", dcnt[1], 32'(VECS[i].c1));
         chk("R3 pba strobes", dcnt[2], 32'(VECS[i].c2));
         chk("R3 pbb strobes", dcnt[3], 32'(VECS[i].c3));
         chk("R7 pbb module 0 follows strobe", mcnt[3], 32'(VECS[i].c3));
         chk("R5 nesting violations", viol, 0);
      end

      // R2: PLL tick as main clock, half rate
      write_reg(3'd0, 32'h1);
      chk("R2 main_sel set", {31'b0, main_sel}, 32'h1);
      write_reg(3'd1, 32'h0);
      wait_cycles(600);
      run_window(512);
      chk("R2 cpu strobes on pll", dcnt[0], 256);
      chk("R2 pbb strobes on pll", dcnt[3], 256);
      write_reg(3'd0, 32'h0);
      chk("R2 main_sel cleared", {31'b0, main_sel}, 32'h0);

      // R6: switch point at counter wrap
      write_reg(3'd1, 32'h87000000);
      wait_cycles(300);
      wait_strobe(3);
      t0 = $time;
      write_reg(3'd1, 32'h80000000);
      wait_strobe(3);
      t1 = $time;
      chk("R6 gap across switch", 32'((t1 - t0) / 4), 256);
      t0 = t1;
      wait_strobe(3);
      t1 = $time;
      chk("R6 R3 new period", 32'((t1 - t0) / 4), 2);

      // R8, R7, R9: mask captured on domain strobe
      write_reg(3'd1, 32'h00870000);
      wait_cycles(300);
      wait_strobe(2);
      write_reg(3'd4, 32'h5);
      wait_strobe(2);
      chk("R8 first strobe keeps old mask bit1", {31'b0, mod_ce[2*MOD_W+1]}, 32'h1);
      wait_strobe(2);
      chk("R7 pba bit0 enabled", {31'b0, mod_ce[2*MOD_W+0]}, 32'h1);
      chk("R8 pba bit1 gated", {31'b0, mod_ce[2*MOD_W+1]}, 32'h0);
      chk("R7 pba bit2 enabled", {31'b0, mod_ce[2*MOD_W+2]}, 32'h1);
      @(posedge clk);
      #1;
      chk("R9 pba strobe low", {31'b0, dom_ce[2]}, 32'h0);
      chk("R9 pba modules low", mod_ce[2*MOD_W +: MOD_W], 32'h0);

      // R7: CPU mask at address 2
      write_reg(3'd2, 32'h0);
      wait_cycles(3);
      @(posedge clk);
      #1;
      chk("R7 cpu strobe running", {31'b0, dom_ce[0]}, 32'h1);
      chk("R7 cpu modules masked", mod_ce[0 +: MOD_W], 32'h0);

      done = 1'b1;
      finish_run();
   end

endmodule